// File: doc/BRIEF.md
# Masked Interrupt Event Controller

This block collects the interrupt events of an Ethernet MAC into one 32-bit event word and raises thirteen separate interrupt request lines from it. Each event has a one-cycle set pulse from the MAC datapath. Software clears events by writing ones to the event word. A separate 32-bit mask word decides which events reach their lines.

Two write side effects are handled here as well. A write to the transmit control address with data bit 0 set marks the graceful-stop-complete event at once. A write to the MAC control address with data bit 0 set wipes both the event word and the mask word. Reads are combinational and select one of four addresses.

Top module: `mac_irq_ctrl`

## Requirements
- R1: While rst_n is low, and after it is released with no other activity, the event word, the mask word and all of irq_o read as zero.
- R2: A one on set_i[k] sets event bit 19+k at the next clock edge. The bits are: 19 underrun, 20 retry limit, 21 late collision, 22 bus error, 23 MII, 24 receive buffer, 25 receive frame, 26 transmit buffer, 27 transmit frame, 28 graceful stop complete, 29 babbling transmit, 30 babbling receive, 31 heartbeat.
- R3: A write to address 0 (event) clears every event bit written as one and leaves bits written as zero unchanged.
- R4: A write to address 1 (mask) loads all 32 bits of wr_data into the mask, and reading address 1 returns it.
- R5: irq_o[i] is high exactly when its event bit and mask bit were both set in the previous cycle. Line i maps to event bit 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30 for i = 0 to 12.
- R6: A write to address 2 (transmit control) with wr_data[0] = 1 sets event bit 28 at the next edge. With wr_data[0] = 0 the write has no effect.
- R7: A write to address 3 (MAC control) with wr_data[0] = 1 clears the event and mask words, even against set pulses in the same cycle. With wr_data[0] = 0 the write has no effect.
- R8: When a set pulse (or the graceful-stop write) and an event clear hit the same bit in one cycle, the bit ends up set.
- R9: Event bits 18 to 0 always read as zero, and reads of addresses 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_i | input | 13 | Event set pulses; bit k sets event bit 19+k |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 event, 1 mask, 2 transmit control, 3 MAC control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same encoding |
| rd_data | output | 32 | Combinational read data |
| irq_o | output | 13 | Registered interrupt request lines |

## Verification
The collisions of interest are a hardware set pulse against a software clear of the same bit, and a set pulse against a control wipe. Both are first forced in directed steps: a clear of all ones alongside one set pulse, and a wipe alongside all thirteen pulses. The random phase then sends sparse pulses together with random writes to every address, so these overlaps recur. Each outcome is judged against a bench model in which a set beats a clear and a wipe beats a set.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;

   localparam int DATA_W  = 32;
   localparam int N_EVT   = 13;
   localparam int EVT_LSB = 19;
   localparam int GRA_POS = 28;
   localparam int ADDR_W  = 2;

   localparam logic [ADDR_W-1:0] A_EVENT = 2'd0;
   localparam logic [ADDR_W-1:0] A_MASK  = 2'd1;
   localparam logic [ADDR_W-1:0] A_TXCTL = 2'd2;
   localparam logic [ADDR_W-1:0] A_MACCTL = 2'd3;

   // Event bit position that feeds each output line, in line order.
   function automatic int line_src(input int line);
      case (line)
         0:  return 27;
         1:  return 26;
         2:  return 19;
         3:  return 20;
         4:  return 25;
         5:  return 24;
         6:  return 23;
         7:  return 21;
         8:  return 31;
         9:  return 28;
         10: return 22;
         11: return 29;
         default: return 30;
      endcase
   endfunction

endpackage

// File: rtl/mac_irq_evt_reg.sv
module mac_irq_evt_reg #(
   parameter int N_EVT   = 13,
   parameter int GRA_IDX = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe_i,
   input  logic [N_EVT-1:0] clr_i,
   input  logic [N_EVT-1:0] set_i,
   input  logic             gra_i,
   output logic [N_EVT-1:0] evt_o
);

   logic [N_EVT-1:0] set_all;
   logic [N_EVT-1:0] evt_d;
   logic [N_EVT-1:0] evt_q;

   always_comb begin
      set_all = set_i;
      if (gra_i) set_all[GRA_IDX] = 1'b1;
      // Wipe beats set; set beats clear.
      if (wipe_i) evt_d = '0;
      else        evt_d = (evt_q & ~clr_i) | set_all;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= evt_d;
   end

   assign evt_o = evt_q;

endmodule

// File: rtl/mac_irq_mask_reg.sv
module mac_irq_mask_reg #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wipe_i,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] mask_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_o <= '0;
      else if (wipe_i) mask_o <= '0;
      else if (load_i) mask_o <= din_i;
   end

endmodule

// File: rtl/mac_irq_line_map.sv
module mac_irq_line_map
   import mac_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_LINE  = 13,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] evt_word_i,
   input  logic [DATA_W-1:0] mask_word_i,
   output logic [N_LINE-1:0] irq_o
);

   logic [N_LINE-1:0] hit;

   for (genvar i = 0; i < N_LINE; i++) begin : g_line
      localparam int SRC = line_src(i);
      assign hit[i] = evt_word_i[SRC] & mask_word_i[SRC];
   end

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_o <= '0;
         else        irq_o <= hit;
      end
   end else begin : g_comb
      assign irq_o = hit;
   end

endmodule

// File: rtl/mac_irq_ctrl.sv
module mac_irq_ctrl
   import mac_irq_pkg::*;
#(
   parameter int DATA_W  = mac_irq_pkg::DATA_W,
   parameter int N_EVT   = mac_irq_pkg::N_EVT,
   parameter int EVT_LSB = mac_irq_pkg::EVT_LSB,
   parameter int GRA_POS = mac_irq_pkg::GRA_POS,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  set_i,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [N_EVT-1:0]  irq_o
);

   localparam int GRA_IDX = GRA_POS - EVT_LSB;
   localparam int EVT_MSB = EVT_LSB + N_EVT - 1;

   initial begin : elab_chk
      assert (EVT_MSB < DATA_W) else $error("event field exceeds data width");
      assert (GRA_IDX >= 0 && GRA_IDX < N_EVT) else $error("graceful stop bit outside field");
   end

   logic             wr_event, wr_mask, wr_tx, wr_mac;
   logic             wipe, gra_hit;
   logic [N_EVT-1:0] evt_q;
   logic [DATA_W-1:0] evt_word;
   logic [DATA_W-1:0] mask_word;

   assign wr_event = wr_en && (wr_addr == A_EVENT);
   assign wr_mask  = wr_en && (wr_addr == A_MASK);
   assign wr_tx    = wr_en && (wr_addr == A_TXCTL);
   assign wr_mac   = wr_en && (wr_addr == A_MACCTL);
   assign wipe     = wr_mac && wr_data[0];
   assign gra_hit  = wr_tx && wr_data[0];

   mac_irq_evt_reg #(
      .N_EVT   (N_EVT),
      .GRA_IDX (GRA_IDX)
   ) u_evt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe_i (wipe),
      .clr_i  (wr_event ? wr_data[EVT_MSB:EVT_LSB] : '0),
      .set_i  (set_i),
      .gra_i  (gra_hit),
      .evt_o  (evt_q)
   );

   mac_irq_mask_reg #(
      .DATA_W (DATA_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .wipe_i (wipe),
      .load_i (wr_mask),
      .din_i  (wr_data),
      .mask_o (mask_word)
   );

   always_comb begin
      evt_word = '0;
      evt_word[EVT_MSB:EVT_LSB] = evt_q;
   end

   mac_irq_line_map #(
      .DATA_W  (DATA_W),
      .N_LINE  (N_EVT),
      .OUT_REG (OUT_REG)
   ) u_map (
      .clk         (clk),
      .rst_n       (rst_n),
      .evt_word_i  (evt_word),
      .mask_word_i (mask_word),
      .irq_o       (irq_o)
   );

   always_comb begin
      case (rd_addr)
         A_EVENT: rd_data = evt_word;
         A_MASK:  rd_data = mask_word;
         default: rd_data = '0;
      endcase
   end

endmodule

// File: rtl/mac_irq_ctrl_chk.sv
module mac_irq_ctrl_chk
   import mac_irq_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int N_EVT   = 13,
   parameter int EVT_LSB = 19,
   parameter int GRA_POS = 28
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  set_i,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] evt_word,
   input logic [DATA_W-1:0] mask_word,
   input logic [N_EVT-1:0]  irq_o
);

   logic [DATA_W-1:0] hw_set;
   logic              wipe;
   assign hw_set = DATA_W'(set_i) << EVT_LSB;
   assign wipe   = wr_en && (wr_addr == A_MACCTL) && wr_data[0];

   p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((|set_i) && !wipe) |=> ((evt_word & $past(hw_set)) == $past(hw_set)));

   // Clear of bits with no concurrent set (R3, set priority R8).
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_EVENT) |=> ((evt_word & $past(wr_data) & ~$past(hw_set)) == '0));

   p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_MASK) |=> (mask_word == $past(wr_data)));

   p_line0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o[0] == $past(evt_word[27] & mask_word[27])));

   p_line2_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o[2] == $past(evt_word[19] & mask_word[19])));

   p_line8_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_o[8] == $past(evt_word[31] & mask_word[31])));

   p_gra_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_TXCTL && wr_data[0]) |=> evt_word[GRA_POS]);

   p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wipe |=> (evt_word == '0 && mask_word == '0));

   p_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_word[EVT_LSB-1:0] == '0);

endmodule

bind mac_irq_ctrl mac_irq_ctrl_chk #(
   .DATA_W  (DATA_W),
   .N_EVT   (N_EVT),
   .EVT_LSB (EVT_LSB),
   .GRA_POS (GRA_POS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .set_i     (set_i),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .evt_word  (evt_word),
   .mask_word (mask_word),
   .irq_o     (irq_o)
);

// File: tb/mac_irq_ctrl_tb.sv
module mac_irq_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] HI = 32'hFFF8_0000;
   localparam int LINE_BIT [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] set_i = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [12:0] irq_o;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   logic [31:0] m_evt = '0;
   logic [31:0] m_mask = '0;
   logic [12:0] m_irq = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mac_irq_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .set_i(set_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .irq_o(irq_o)
   );

   function automatic logic [12:0] lines_of(logic [31:0] e, logic [31:0] m);
      logic [12:0] r;
      for (int i = 0; i < 13; i++) r[i] = e[LINE_BIT[i]] & m[LINE_BIT[i]];
      return r;
   endfunction

   function automatic logic [31:0] read_of(logic [1:0] a);
      case (a)
         2'd0: return m_evt;
         2'd1: return m_mask;
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Called just after a falling edge: drive, check read, clock, update model, check lines.
   task automatic apply(bit we, logic [1:0] a, logic [31:0] d, logic [12:0] s, logic [1:0] ra);
      logic [31:0] setw;
      wr_en = we; wr_addr = a; wr_data = d; set_i = s; rd_addr = ra;
      #1;
      check(ra == 2'd0 ? "R2 event read" : (ra == 2'd1 ? "R4 mask read" : "R9 zero read"),
            rd_data, read_of(ra));
      check("R9 low event bits", {13'h0, rd_data[18:0] & {19{ra == 2'd0}}}, 32'h0);
      @(posedge clk);
      m_irq = lines_of(m_evt, m_mask);
      setw = {s, 19'h0};
      if (we && a == 2'd2 && d[0]) setw[28] = 1'b1;
      if (we && a == 2'd3 && d[0]) begin
         m_evt = '0; m_mask = '0;
      end else begin
         m_evt = ((m_evt & ~((we && a == 2'd0) ? d : 32'h0)) | setw) & HI;
         if (we && a == 2'd1) m_mask = d;
      end
      @(negedge clk);
      check("R5 lines", {19'h0, irq_o}, {19'h0, m_irq});
      wr_en = 1'b0; set_i = '0;
   endtask

   task automatic peek(string tag, logic [1:0] a, logic [31:0] exp);
      rd_addr = a;
      #1;
      check(tag, rd_data, exp);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      peek("R1 event in reset", 2'd0, 32'h0);
      check("R1 lines in reset", {19'h0, irq_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      peek("R1 event after reset", 2'd0, 32'h0);
      peek("R1 mask after reset", 2'd1, 32'h0);
      check("R1 lines after reset", {19'h0, irq_o}, 32'h0);

      apply(1, 2'd1, 32'hFFFF_FFFF, '0, 2'd1);
      peek("R4 mask load", 2'd1, 32'hFFFF_FFFF);
      apply(0, 2'd0, 32'h0, 13'h1FFF, 2'd0);
      peek("R2 all set", 2'd0, 32'hFFF8_0000);
      apply(0, 2'd0, 32'h0, '0, 2'd0);
      check("R5 all lines", {19'h0, irq_o}, 32'h1FFF);

      apply(1, 2'd0, 32'h0800_0001, '0, 2'd0);
      peek("R3 clear bit 27", 2'd0, 32'hF7F8_0000);
      apply(0, 2'd0, 32'h0, '0, 2'd0);
      check("R5 line 0 dropped", {19'h0, irq_o}, 32'h1FFE);

      apply(1, 2'd3, 32'h1, 13'h1FFF, 2'd0);
      peek("R7 wipe event vs set", 2'd0, 32'h0);
      peek("R7 wipe mask", 2'd1, 32'h0);
      apply(1, 2'd1, 32'h1234_5678, '0, 2'd1);
      apply(1, 2'd3, 32'h2, '0, 2'd1);
      peek("R7 bit0 clear no effect", 2'd1, 32'h1234_5678);

      apply(1, 2'd2, 32'h0, '0, 2'd0);
      peek("R6 tx write bit0 zero", 2'd0, 32'h0);
      apply(1, 2'd2, 32'h1, '0, 2'd0);
      peek("R6 graceful stop set", 2'd0, 32'h1000_0000);

      apply(1, 2'd0, 32'hFFFF_FFFF, 13'h0080, 2'd0);
      peek("R8 set beats clear", 2'd0, 32'h0400_0000);
      apply(1, 2'd0, 32'h0400_0000, '0, 2'd2);
      peek("R9 addr2 reads zero", 2'd2, 32'h0);
      peek("R9 addr3 reads zero", 2'd3, 32'h0);
      peek("R3 event cleared", 2'd0, 32'h0);

      for (int n = 0; n < 3000; n++) begin
         logic [12:0] s;
         logic [1:0]  a;
         logic [31:0] d;
         s = ($urandom_range(0, 3) == 0) ? 13'(1 << $urandom_range(0, 12)) : 13'h0;
         if ($urandom_range(0, 9) == 0) s = 13'($urandom);
         a = 2'($urandom);
         d = $urandom;
         if (a == 2'd3 && $urandom_range(0, 7) != 0) d[0] = 1'b0;
         apply($urandom_range(0, 2) != 0, a, d, s, 2'($urandom));
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule